// File: doc/BRIEF.md
# Receive Character Queue with Command Control

This block sits between a serial receive engine and the host side of an asynchronous serial controller. Each received character arrives on a valid/data strobe as an 11-bit entry: nine data bits and two status bits. The block stores these entries in a small circular queue of four slots. The host can limit the usable depth to anything from one to four slots. The host drains the queue one entry per read strobe and watches an occupancy count. An interrupt request rises once the occupancy reaches a programmable threshold.

A single command byte controls the queue. It can switch reception on or off, flush the receive machine, empty the queue, and lock or unlock writes. Several of these actions may share one byte, and they resolve by fixed rules:
- An unlock request, or a receive-machine flush, beats a lock request in the same byte.
- An emptying action beats any character or read in the same cycle.

A read of an empty queue, and the lock and unlock actions, never disturb the read or write position. A separate clear strobe, driven when software writes zero to the level bit of the line status, empties the queue in the same way as the flush command.

Top module: `rx_cmd_fifo`

## Requirements
- R1: After reset, level is 0 and irq, locked, rx_enabled, overrun and rd_valid are all 0.
- R2: A character is accepted when rx_enabled is 1, the queue is unlocked and the queue is not full. An accepted character raises level by one at the next clock edge. Entries leave in arrival order. For a read strobe on a non-empty queue, rd_data holds the oldest entry and rd_valid is 1 one cycle after the strobe, and level drops by one.
- R3: The usable depth is depth_sel clamped to the range 1..4, so a value of 0 acts as 1. When level has reached the usable depth, a character offered on an enabled, unlocked queue is dropped and overrun becomes 1. Overrun then stays 1 until a receive-machine flush, and the stored entries are unchanged.
- R4: A read strobe on an empty queue gives rd_valid 0 one cycle later and leaves level and both positions unchanged. The next character written is the next one read.
- R5: Bit 4 of a command byte, or a pulse on lvl_clr, sets level to 0 at the next edge. Any character or read in that same cycle is ignored. Arrival order is intact afterwards.
- R6: Bit 3 of a command byte sets locked. While locked, characters are dropped without setting overrun. Bit 2 clears locked without moving the write position, so the next accepted character is read back correctly.
- R7: Bit 5 of a command byte clears locked and clears overrun. If bit 3 is also set in the same byte, or bit 3 and bit 2 are set together, locked ends at 0.
- R8: Every command byte loads rx_enabled from its bit 7. While rx_enabled is 0, characters are dropped and level does not change.
- R9: irq is 1 exactly when level is at least max(thresh,1). It updates at the same edge as level.
- R10: A character and a read strobe in the same cycle, on a queue that is neither empty nor full, both take effect and leave level unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive engine offers a character this cycle |
| rx_entry | input | 11 | Character with status: data in bits 8:0, status in bits 10:9 |
| cmd_we | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command: bit 7 enable, bit 5 flush receive machine, bit 4 flush queue, bit 3 lock, bit 2 unlock |
| lvl_clr | input | 1 | Empty the queue (zero written to level status bit) |
| depth_sel | input | 3 | Usable depth, clamped to 1..4 |
| thresh | input | 3 | Interrupt occupancy threshold (0 acts as 1) |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 11 | Entry returned by the previous read |
| rd_valid | output | 1 | rd_data holds a real entry from the previous read |
| level | output | 3 | Current occupancy 0..4 |
| irq | output | 1 | Occupancy at or above threshold |
| locked | output | 1 | Writes into the queue are blocked |
| rx_enabled | output | 1 | Reception switched on |
| overrun | output | 1 | Sticky: a character was dropped on a full queue |

## Verification
Every result of this block lands one clock edge after the stimulus that causes it. This covers a character's effect on level and irq, rd_data and rd_valid after a read strobe, and every command effect. The bench drives each stimulus just after a falling edge and lets exactly one rising edge pass. It then checks the outputs at the following falling edge. Because of this, a dropped character or a lost lock is seen in the very cycle it would have shown. Cases that rely on same-cycle priority are applied in one cycle, then observed one edge later. These are a flush together with a character, lock together with a receive-machine flush, and a read together with a write.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CMD_W          = 8;
  localparam int BIT_ENABLE     = 7;
  localparam int BIT_FLUSH_MACH = 5;
  localparam int BIT_FLUSH_Q    = 4;
  localparam int BIT_LOCK       = 3;
  localparam int BIT_UNLOCK     = 2;

  // Resolved command actions, after the priority rules are applied.
  typedef struct packed {
    logic valid;
    logic enable;
    logic flush_mach;
    logic flush_q;
    logic set_lock;
    logic clr_lock;
  } rxq_cmd_t;
endpackage

// File: rtl/rxq_cmd_decode.sv
module rxq_cmd_decode
  import rxq_pkg::*;
(
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_byte,
  output rxq_cmd_t         cmd
);
  logic unused_bits;
  assign unused_bits = ^{cmd_byte[6], cmd_byte[1:0]};

  always_comb begin
    cmd            = '0;
    cmd.valid      = cmd_we;
    cmd.enable     = cmd_byte[BIT_ENABLE];
    cmd.flush_mach = cmd_we & cmd_byte[BIT_FLUSH_MACH];
    cmd.flush_q    = cmd_we & cmd_byte[BIT_FLUSH_Q];
    // A machine flush implies unlock; unlock outranks lock.
    cmd.clr_lock   = cmd_we & (cmd_byte[BIT_UNLOCK] | cmd_byte[BIT_FLUSH_MACH]);
    cmd.set_lock   = cmd_we & cmd_byte[BIT_LOCK] & ~cmd.clr_lock;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int W     = 11,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic             re,
  input  logic [PTR_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  rxq_cmd_t         cmd,
  input  logic             lvl_clr,
  input  logic             rx_valid,
  input  logic             rd_en,
  input  logic [LVL_W-1:0] depth_sel,
  input  logic [LVL_W-1:0] thresh,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic             re,
  output logic [PTR_W-1:0] raddr,
  output logic             rd_valid,
  output logic [LVL_W-1:0] level,
  output logic             irq,
  output logic             locked,
  output logic             rx_enabled,
  output logic             overrun
);
  localparam logic [LVL_W-1:0] CAP_MAX = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0] wptr, rptr;
  logic [LVL_W-1:0] cap, thr_eff, lvl_nxt;
  logic clear, full, empty, push_try, do_push, do_pop, ovf;

  always_comb begin
    if (depth_sel == '0)          cap = LVL_W'(1);
    else if (depth_sel > CAP_MAX) cap = CAP_MAX;
    else                          cap = depth_sel;
    thr_eff  = (thresh == '0) ? LVL_W'(1) : thresh;
    clear    = cmd.flush_q | lvl_clr;
    full     = level >= cap;
    empty    = level == '0;
    push_try = rx_valid & rx_enabled & ~locked & ~clear;
    do_push  = push_try & ~full;
    ovf      = push_try & full;
    do_pop   = rd_en & ~empty & ~clear;
    if (clear) lvl_nxt = '0;
    else       lvl_nxt = level + LVL_W'(do_push) - LVL_W'(do_pop);
  end

  assign we    = do_push;
  assign waddr = wptr;
  assign re    = do_pop;
  assign raddr = rptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      level <= '0;
      irq <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      level    <= lvl_nxt;
      irq      <= lvl_nxt >= thr_eff;
      rd_valid <= do_pop;
      if (clear) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (do_push) wptr <= bump(wptr);
        if (do_pop)  rptr <= bump(rptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      rx_enabled <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (cmd.valid) rx_enabled <= cmd.enable;
      if (cmd.clr_lock)      locked <= 1'b0;
      else if (cmd.set_lock) locked <= 1'b1;
      if (cmd.flush_mach) overrun <= 1'b0;
      else if (ovf)       overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_cmd_fifo.sv
module rx_cmd_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int STAT_W = 2,
  parameter int DEPTH  = 4,
  localparam int ENT_W = DATA_W + STAT_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [ENT_W-1:0] rx_entry,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             lvl_clr,
  input  logic [LVL_W-1:0] depth_sel,
  input  logic [LVL_W-1:0] thresh,
  input  logic             rd_en,
  output logic [ENT_W-1:0] rd_data,
  output logic             rd_valid,
  output logic [LVL_W-1:0] level,
  output logic             irq,
  output logic             locked,
  output logic             rx_enabled,
  output logic             overrun
);
  rxq_cmd_t         cmd;
  logic             mem_we, mem_re;
  logic [PTR_W-1:0] mem_waddr, mem_raddr;

  rxq_cmd_decode u_dec (
    .cmd_we   (cmd_we),
    .cmd_byte (cmd_byte),
    .cmd      (cmd)
  );

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .lvl_clr    (lvl_clr),
    .rx_valid   (rx_valid),
    .rd_en      (rd_en),
    .depth_sel  (depth_sel),
    .thresh     (thresh),
    .we         (mem_we),
    .waddr      (mem_waddr),
    .re         (mem_re),
    .raddr      (mem_raddr),
    .rd_valid   (rd_valid),
    .level      (level),
    .irq        (irq),
    .locked     (locked),
    .rx_enabled (rx_enabled),
    .overrun    (overrun)
  );

  rxq_store #(.W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (rx_entry),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/rxq_check.sv
module rxq_check #(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_we,
  input logic [7:0]       cmd_byte,
  input logic             rx_valid,
  input logic             rd_en,
  input logic [LVL_W-1:0] thresh,
  input logic [LVL_W-1:0] level,
  input logic             rd_valid,
  input logic             irq,
  input logic             locked,
  input logic             overrun
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && level == '0) |=> !rd_valid);

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_byte[4]) |=> level == '0);

  assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (locked && !cmd_we && rx_valid) |=> level <= $past(level));

  assert_unlock_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_byte[5]) |=> (!locked && !overrun));

  assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (overrun && !(cmd_we && cmd_byte[5])) |=> overrun);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (level != '0 && level >= (($past(thresh) == '0) ? LVL_W'(1) : $past(thresh))));
endmodule

bind rx_cmd_fifo rxq_check #(.DEPTH(DEPTH)) u_check (
  .clk      (clk),
  .rst      (rst),
  .cmd_we   (cmd_we),
  .cmd_byte (cmd_byte),
  .rx_valid (rx_valid),
  .rd_en    (rd_en),
  .thresh   (thresh),
  .level    (level),
  .rd_valid (rd_valid),
  .irq      (irq),
  .locked   (locked),
  .overrun  (overrun)
);

// File: tb/rx_cmd_fifo_test.sv
`timescale 1ns/1ps
module rx_cmd_fifo_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [10:0] rx_entry = '0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        lvl_clr = 1'b0;
  logic [2:0]  depth_sel = 3'd4;
  logic [2:0]  thresh = 3'd2;
  logic        rd_en = 1'b0;
  logic [10:0] rd_data;
  logic        rd_valid, irq, locked, rx_enabled, overrun;
  logic [2:0]  level;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_cmd_fifo uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_entry(rx_entry),
    .cmd_we(cmd_we), .cmd_byte(cmd_byte), .lvl_clr(lvl_clr),
    .depth_sel(depth_sel), .thresh(thresh), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .level(level), .irq(irq),
    .locked(locked), .rx_enabled(rx_enabled), .overrun(overrun)
  );

  // Vector: {op[1:0], push_data[10:0], exp_level[2:0], exp_valid, exp_data[10:0]}
  // op 0 push, 1 read, 2 push and read together
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 11'h101, 3'd1, 1'b0, 11'h000},
    {2'd0, 11'h0A5, 3'd2, 1'b0, 11'h000},
    {2'd1, 11'h000, 3'd1, 1'b1, 11'h101},
    {2'd2, 11'h3C3, 3'd1, 1'b1, 11'h0A5},
    {2'd0, 11'h7FF, 3'd2, 1'b0, 11'h000},
    {2'd0, 11'h001, 3'd3, 1'b0, 11'h000},
    {2'd1, 11'h000, 3'd2, 1'b1, 11'h3C3},
    {2'd1, 11'h000, 3'd1, 1'b1, 11'h7FF},
    {2'd1, 11'h000, 3'd0, 1'b1, 11'h001},
    {2'd1, 11'h000, 3'd0, 1'b0, 11'h000},
    {2'd0, 11'h555, 3'd1, 1'b0, 11'h000},
    {2'd1, 11'h000, 3'd0, 1'b1, 11'h555}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus; outputs are valid on return.
  task automatic step(input bit push, input logic [10:0] d, input bit rd,
                      input bit cw, input logic [7:0] cb, input bit clr);
    rx_valid = push; rx_entry = d; rd_en = rd;
    cmd_we = cw; cmd_byte = cb; lvl_clr = clr;
    @(negedge clk);
    rx_valid = 0; rd_en = 0; cmd_we = 0; lvl_clr = 0;
  endtask

  task automatic push(input logic [10:0] d); step(1, d, 0, 0, 8'h00, 0); endtask
  task automatic pop();                      step(0, '0, 1, 0, 8'h00, 0); endtask
  task automatic cmd(input logic [7:0] b);   step(0, '0, 0, 1, b, 0); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 level", level, 0);
    check("R1 flags", {irq, locked, rx_enabled, overrun, rd_valid}, 0);

    // R8 disabled queue drops characters
    push(11'h12A);
    check("R8 disabled drop", level, 0);
    cmd(8'h80);
    check("R8 enable", rx_enabled, 1);

    // Table walk: R2 order, R10 simultaneous, R4 empty read, R9 irq
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      step(v[27:26] != 2'd1, v[25:15], v[27:26] != 2'd0, 0, 8'h00, 0);
      check($sformatf("R2/R10 level vec%0d", i), level, v[14:12]);
      check($sformatf("R4 valid vec%0d", i), rd_valid, v[11]);
      if (v[11]) check($sformatf("R2 data vec%0d", i), rd_data, v[10:0]);
      check($sformatf("R9 irq vec%0d", i), irq, v[14:12] >= 3'd2);
    end

    // R3 reduced depth and overrun
    depth_sel = 3'd2;
    push(11'h011); push(11'h022); push(11'h033);
    check("R3 level capped", level, 2);
    check("R3 overrun set", overrun, 1);
    push(11'h044);
    check("R3 overrun sticky", overrun, 1);
    pop(); check("R3 kept first", rd_data, 11'h011);
    pop(); check("R3 kept second", rd_data, 11'h022);
    depth_sel = 3'd0;
    push(11'h055); push(11'h066);
    check("R3 depth zero acts as one", level, 1);
    pop(); check("R3 depth one data", rd_data, 11'h055);
    depth_sel = 3'd4;

    // R7 machine flush beats lock, clears overrun
    cmd(8'hA8);
    check("R7 unlocked", locked, 0);
    check("R7 overrun cleared", overrun, 0);
    cmd(8'h8C);
    check("R7 unlock beats lock", locked, 0);

    // R6 lock / unlock
    push(11'h101);
    cmd(8'h88);
    check("R6 locked", locked, 1);
    push(11'h1EE);
    check("R6 locked drop", level, 1);
    check("R6 no overrun", overrun, 0);
    cmd(8'h84);
    check("R6 unlocked", locked, 0);
    push(11'h2DD);
    pop(); check("R6 order first", rd_data, 11'h101);
    pop(); check("R6 write pos kept", rd_data, 11'h2DD);

    // R5 flush command and lvl_clr, with same-cycle character
    push(11'h0F0); push(11'h0E0);
    step(1, 11'h0D0, 0, 1, 8'h90, 0);
    check("R5 flush cmd", level, 0);
    push(11'h0C0);
    step(1, 11'h0B0, 0, 0, 8'h00, 1);
    check("R5 lvl_clr", level, 0);
    push(11'h0A0);
    pop();
    check("R5 order after flush", rd_data, 11'h0A0);
    check("R5 valid after flush", rd_valid, 1);

    // R9 threshold variants
    thresh = 3'd3;
    push(11'h001); push(11'h002);
    check("R9 below thresh", irq, 0);
    push(11'h003);
    check("R9 at thresh", irq, 1);
    cmd(8'h90);
    thresh = 3'd0;
    push(11'h004);
    check("R9 thresh zero", irq, 1);

    // R8 disable via command bit 7 clear
    cmd(8'h00);
    check("R8 disabled", rx_enabled, 0);
    push(11'h005);
    check("R8 drop when off", level, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule